// File: doc/BRIEF.md
# Comparator Output Conditioner

This block sits between the one-bit digital output of an analog comparator and the PWM control logic that acts on it. It cleans that bit up in a fixed order of stages. An optional clock synchroniser comes first, then an optional inversion, then a glitch filter with a programmable stability window, and last a blanking stage. The blanking stage freezes the result for a programmed number of cycles after a chosen edge of the filtered signal, or after a pulse on one of sixteen external trigger lines.

The glitch filter can run all the time. It can also run only while one of two reference values is selected, which is shown by a one-bit flag. Whenever the filter is not in use, the signal passes around it with no added delay. The filter is a two-state machine with states FLT_STEADY and FLT_QUALIFY:
- A sampled level that differs from the held level moves it from FLT_STEADY to FLT_QUALIFY.
- A return to the held level moves it back to FLT_STEADY.
- Reaching the window moves it back to FLT_STEADY and adopts the new level.
- Bypass forces FLT_STEADY.

The blanker has states BLK_OPEN and BLK_HOLD. A start event moves it from BLK_OPEN to BLK_HOLD. It returns to BLK_OPEN on the last counted cycle.

Top module: `cmpout_conditioner`

## Requirements
- R1: While reset is asserted, and directly after it, `cmp_o` and `blank_act_o` are 0, whatever the raw input is.
- R2: With the filter unused and blanking idle, `cmp_o` follows the processed input one clock edge after the raw bit is sampled when `sync_en_i`=0. It follows three edges after when `sync_en_i`=1, because of two synchroniser stages.
- R3: With `inv_en_i`=1 the conditioned output is the complement of the raw level; with 0 it equals it.
- R4: With filtering applied, a new level must be sampled on N consecutive edges before it is accepted. N is `filt_win_i`+2 for codes 0 to 14 and 32 for code 15. A pulse of N cycles shows on `cmp_o` N+1 edges after its start; a pulse of N-1 cycles never shows.
- R5: Filter control `filt_ctrl_i` selects when filtering applies: 0 and 3 mean always, 1 means only while `ref_sel_i`=0, and 2 means only while `ref_sel_i`=1.
- R6: With `filt_en_i`=0, or when the control does not apply the filter, the signal bypasses the filter with no added delay and no pulse suppression.
- R7: Blanking mode `blank_mode_i` starts blanking on edges of the filtered signal: 0 never, 1 on a rise, 2 on a fall, 3 on both.
- R8: With `ext_blank_en_i`=1, a high level on bit `ext_sel_i` of `ext_trig_i` at an edge while blanking is idle starts blanking. The other 15 lines, and every line when the enable is 0, have no effect.
- R9: `blank_act_o` stays high for exactly `blank_len_i` cycles, a value captured at the start event. A length of 0 disables blanking. Start events during blanking are ignored.
- R10: While blanking is active, `cmp_o` holds the level it had before the start event. It resumes tracking on the edge after `blank_act_o` falls, so an edge that starts blanking reaches `cmp_o` `blank_len_i`+2 edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | 1 | Raw comparator bit |
| sync_en_i | input | 1 | Enable the input synchroniser |
| inv_en_i | input | 1 | Invert the comparator bit |
| filt_en_i | input | 1 | Enable the glitch filter |
| filt_win_i | input | 4 | Filter window code |
| filt_ctrl_i | input | 2 | Filter gating by reference selection |
| ref_sel_i | input | 1 | 0: first reference value active, 1: second |
| blank_mode_i | input | 2 | Edge selection that starts blanking |
| ext_blank_en_i | input | 1 | Enable external blanking triggers |
| ext_sel_i | input | 4 | Index of the external trigger line |
| blank_len_i | input | 8 | Blanking duration in cycles |
| ext_trig_i | input | 16 | External trigger lines |
| cmp_o | output | 1 | Conditioned comparator bit |
| blank_act_o | output | 1 | Blanking window active |

## Verification
The bench sweeps every window code with pulses one cycle shorter than the window and exactly as long as it. A design with an off-by-one counter, or with a linear decode of the top code, would then pass a short pulse, drop the long one, or show it on the wrong edge. It crosses every filter-control code with both reference selections and the enable. A wrong gating decode would then suppress a pulse that should bypass, or the reverse. It checks every trigger selector against every trigger line, and the blanking lengths 0, 1, 6 and 255. A selector decode error, or a counter that retriggers or runs one cycle long, would give a blanking count other than the programmed one. Edges removed by the filter must not start blanking. This exposes a design that detects edges before the filter.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;

    typedef enum logic [1:0] {
        BM_OFF  = 2'd0,
        BM_RISE = 2'd1,
        BM_FALL = 2'd2,
        BM_BOTH = 2'd3
    } blank_mode_e;

    typedef enum logic [1:0] {
        FC_ALWAYS     = 2'd0,
        FC_REF_A      = 2'd1,
        FC_REF_B      = 2'd2,
        FC_ALWAYS_ALT = 2'd3
    } filt_ctrl_e;

    typedef enum logic {
        FLT_STEADY  = 1'b0,
        FLT_QUALIFY = 1'b1
    } flt_state_e;

    typedef enum logic {
        BLK_OPEN = 1'b0,
        BLK_HOLD = 1'b1
    } blk_state_e;

endpackage

// File: rtl/cmpc_sync.sv
module cmpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    // Stage k samples stage k-1; stage 0 samples the raw input.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[k] <= 1'b0;
                else        chain_q[k] <= chain_q[k-1];
            end
        end
    end

    assign dout = en ? chain_q[STAGES-1] : din;

endmodule

// File: rtl/cmpc_glitch_filter.sv
module cmpc_glitch_filter
    import cmpc_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int LONG_WIN = 32,
    localparam int CNT_W   = $clog2(LONG_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              enable,
    input  logic [CODE_W-1:0] win_code,
    input  logic [1:0]        ctrl,
    input  logic              ref_sel,
    output logic              dout,
    output logic              applied
);

    flt_state_e       state_q, state_d;
    logic             level_q, level_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] win_len;
    filt_ctrl_e       ctrl_e;

    assign ctrl_e = filt_ctrl_e'(ctrl);

    // Window decode: the all-ones code selects the long window, others add two.
    always_comb begin
        if (win_code == {CODE_W{1'b1}}) win_len = CNT_W'(LONG_WIN);
        else                            win_len = CNT_W'(win_code) + CNT_W'(2);
    end

    // Gating by which reference value is currently driven.
    always_comb begin
        unique case (ctrl_e)
            FC_ALWAYS:     applied = enable;
            FC_REF_A:      applied = enable && !ref_sel;
            FC_REF_B:      applied = enable && ref_sel;
            FC_ALWAYS_ALT: applied = enable;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            level_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        level_d = level_q;
        cnt_d   = cnt_q;
        if (!applied) begin
            state_d = FLT_STEADY;
            level_d = din;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FLT_STEADY: begin
                    if (din != level_q) begin
                        state_d = FLT_QUALIFY;
                        cnt_d   = CNT_W'(1);
                    end
                end
                FLT_QUALIFY: begin
                    if (din == level_q) begin
                        state_d = FLT_STEADY;
                        cnt_d   = '0;
                    end else if ((cnt_q + CNT_W'(1)) == win_len) begin
                        state_d = FLT_STEADY;
                        level_d = din;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Output.
    always_comb begin
        dout = applied ? level_q : din;
    end

endmodule

// File: rtl/cmpc_blanker.sv
module cmpc_blanker
    import cmpc_pkg::*;
#(
    parameter int TRIG_N = 16,
    parameter int LEN_W  = 8,
    localparam int SEL_W = $clog2(TRIG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [1:0]        mode,
    input  logic              ext_en,
    input  logic [SEL_W-1:0]  ext_sel,
    input  logic [TRIG_N-1:0] ext_trig,
    input  logic [LEN_W-1:0]  len,
    output logic              dout,
    output logic              active
);

    blk_state_e       state_q, state_d;
    logic             out_q, out_d;
    logic             prev_q;
    logic [LEN_W-1:0] remain_q, remain_d;
    logic             rise, fall, edge_hit, ext_hit, start;
    blank_mode_e      mode_e;

    assign mode_e = blank_mode_e'(mode);
    assign rise   = din && !prev_q;
    assign fall   = !din && prev_q;

    always_comb begin
        unique case (mode_e)
            BM_OFF:  edge_hit = 1'b0;
            BM_RISE: edge_hit = rise;
            BM_FALL: edge_hit = fall;
            BM_BOTH: edge_hit = rise || fall;
        endcase
    end

    assign ext_hit = ext_en && ext_trig[ext_sel];
    assign start   = (edge_hit || ext_hit) && (len != '0);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= BLK_OPEN;
            out_q    <= 1'b0;
            prev_q   <= 1'b0;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            out_q    <= out_d;
            prev_q   <= din;
            remain_q <= remain_d;
        end
    end

    // Next state.
    always_comb begin
        state_d  = state_q;
        out_d    = out_q;
        remain_d = remain_q;
        unique case (state_q)
            BLK_OPEN: begin
                if (start) begin
                    state_d  = BLK_HOLD;
                    remain_d = len;
                end else begin
                    out_d = din;
                end
            end
            BLK_HOLD: begin
                if (remain_q == LEN_W'(1)) begin
                    state_d  = BLK_OPEN;
                    remain_d = '0;
                end else begin
                    remain_d = remain_q - LEN_W'(1);
                end
            end
        endcase
    end

    // Outputs.
    always_comb begin
        dout   = out_q;
        active = (state_q == BLK_HOLD);
    end

endmodule

// File: rtl/cmpout_conditioner.sv
module cmpout_conditioner #(
    parameter int SYNC_STAGES = 2,
    parameter int CODE_W      = 4,
    parameter int LONG_WIN    = 32,
    parameter int TRIG_N      = 16,
    parameter int LEN_W       = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmp_raw_i,
    input  logic                      sync_en_i,
    input  logic                      inv_en_i,
    input  logic                      filt_en_i,
    input  logic [CODE_W-1:0]         filt_win_i,
    input  logic [1:0]                filt_ctrl_i,
    input  logic                      ref_sel_i,
    input  logic [1:0]                blank_mode_i,
    input  logic                      ext_blank_en_i,
    input  logic [$clog2(TRIG_N)-1:0] ext_sel_i,
    input  logic [LEN_W-1:0]          blank_len_i,
    input  logic [TRIG_N-1:0]         ext_trig_i,
    output logic                      cmp_o,
    output logic                      blank_act_o
);

    logic sync_out;
    logic pre_flt;
    logic flt_out;
    logic flt_applied;

    cmpc_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_raw_i),
        .en    (sync_en_i),
        .dout  (sync_out)
    );

    assign pre_flt = sync_out ^ inv_en_i;

    cmpc_glitch_filter #(
        .CODE_W   (CODE_W),
        .LONG_WIN (LONG_WIN)
    ) filt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (pre_flt),
        .enable   (filt_en_i),
        .win_code (filt_win_i),
        .ctrl     (filt_ctrl_i),
        .ref_sel  (ref_sel_i),
        .dout     (flt_out),
        .applied  (flt_applied)
    );

    cmpc_blanker #(
        .TRIG_N (TRIG_N),
        .LEN_W  (LEN_W)
    ) blank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (flt_out),
        .mode     (blank_mode_i),
        .ext_en   (ext_blank_en_i),
        .ext_sel  (ext_sel_i),
        .ext_trig (ext_trig_i),
        .len      (blank_len_i),
        .dout     (cmp_o),
        .active   (blank_act_o)
    );

endmodule

// File: rtl/cmpc_checker.sv
module cmpc_checker #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_raw_i,
    input logic             sync_en_i,
    input logic             inv_en_i,
    input logic             filt_en_i,
    input logic [1:0]       blank_mode_i,
    input logic             ext_blank_en_i,
    input logic [LEN_W-1:0] blank_len_i,
    input logic             cmp_o,
    input logic             blank_act_o,
    input logic             pre_flt,
    input logic             flt_out,
    input logic             flt_applied
);

    logic [LEN_W:0]   run_q;
    logic [LEN_W-1:0] cap_q;

    // Length of the current blanking run and the length captured at its start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            cap_q <= '0;
        end else if (!blank_act_o) begin
            run_q <= (LEN_W + 1)'(1);
            cap_q <= blank_len_i;
        end else begin
            run_q <= run_q + (LEN_W + 1)'(1);
        end
    end

    // R2, R3: direct path when nothing else is in the way
    assert_bypass_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt_en_i && !sync_en_i && !blank_act_o && blank_mode_i == 2'd0 && !ext_blank_en_i)
        |=> cmp_o == ($past(cmp_raw_i) ^ $past(inv_en_i)));

    // R4: the filter only accepts a level seen on at least two consecutive edges
    assert_filter_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_applied && $past(flt_applied) && $past(flt_applied, 2) && flt_out != $past(flt_out))
        |-> ($past(pre_flt) == flt_out && $past(pre_flt, 2) == flt_out));

    // R7: no start event source means no blanking
    assert_no_blank_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_mode_i == 2'd0 && !ext_blank_en_i && !blank_act_o) |=> !blank_act_o);

    // R9: a run never exceeds the captured length
    assert_blank_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blank_act_o |-> (run_q <= {1'b0, cap_q}));

    // R10: output frozen while blanking
    assert_hold_while_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        blank_act_o |-> $stable(cmp_o));

endmodule

bind cmpout_conditioner cmpc_checker #(
    .LEN_W (LEN_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmp_raw_i      (cmp_raw_i),
    .sync_en_i      (sync_en_i),
    .inv_en_i       (inv_en_i),
    .filt_en_i      (filt_en_i),
    .blank_mode_i   (blank_mode_i),
    .ext_blank_en_i (ext_blank_en_i),
    .blank_len_i    (blank_len_i),
    .cmp_o          (cmp_o),
    .blank_act_o    (blank_act_o),
    .pre_flt        (pre_flt),
    .flt_out        (flt_out),
    .flt_applied    (flt_applied)
);

// File: tb/cmpout_conditioner_tb_top.sv
`timescale 1ns/1ps
module cmpout_conditioner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_raw = 1'b0;
    logic        sync_en = 1'b0;
    logic        inv_en = 1'b0;
    logic        filt_en = 1'b0;
    logic [3:0]  filt_win = 4'd0;
    logic [1:0]  filt_ctrl = 2'd0;
    logic        ref_sel = 1'b0;
    logic [1:0]  blank_mode = 2'd0;
    logic        ext_en = 1'b0;
    logic [3:0]  ext_sel = 4'd0;
    logic [7:0]  blank_len = 8'd6;
    logic [15:0] ext_trig = 16'd0;
    logic        cmp_o;
    logic        blank_act;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    cmpout_conditioner dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmp_raw_i      (cmp_raw),
        .sync_en_i      (sync_en),
        .inv_en_i       (inv_en),
        .filt_en_i      (filt_en),
        .filt_win_i     (filt_win),
        .filt_ctrl_i    (filt_ctrl),
        .ref_sel_i      (ref_sel),
        .blank_mode_i   (blank_mode),
        .ext_blank_en_i (ext_en),
        .ext_sel_i      (ext_sel),
        .blank_len_i    (blank_len),
        .ext_trig_i     (ext_trig),
        .cmp_o          (cmp_o),
        .blank_act_o    (blank_act)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a new raw level and external pulses; report first output change and blank count.
    task automatic probe(input bit new_raw, input logic [15:0] ext0, input logic [15:0] ext2,
                         input int n, output int lat, output int bcnt);
        bit start_lvl;
        start_lvl = cmp_o;
        lat = 0;
        bcnt = 0;
        cmp_raw = new_raw;
        ext_trig = ext0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (lat == 0 && cmp_o != start_lvl) lat = k;
            if (blank_act) bcnt++;
            ext_trig = (k == 2) ? ext2 : 16'd0;
        end
    endtask

    // Raw high for len cycles starting from a low level.
    task automatic pulse(input int len, input int tail, output int first, output int bcnt);
        first = 0;
        bcnt = 0;
        cmp_raw = 1'b1;
        for (int k = 1; k <= len + tail; k++) begin
            @(negedge clk);
            if (first == 0 && cmp_o) first = k;
            if (blank_act) bcnt++;
            if (k == len) cmp_raw = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lat, bc, first, win, exp_first;
        bit hit, bypass;

        // R1: reset state with raw high
        cmp_raw = 1'b1;
        settle(4);
        check(cmp_o == 1'b0, "R1 cmp_o in reset", cmp_o, 0);
        check(blank_act == 1'b0, "R1 blank_act in reset", blank_act, 0);
        cmp_raw = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmp_o == 1'b0, "R1 cmp_o after reset", cmp_o, 0);
        check(blank_act == 1'b0, "R1 blank_act after reset", blank_act, 0);

        // R2, R3: latency and inversion
        for (int s = 0; s < 2; s++) begin
            for (int iv = 0; iv < 2; iv++) begin
                sync_en = s[0];
                inv_en = iv[0];
                cmp_raw = 1'b0;
                settle(6);
                check(cmp_o == iv[0], "R3 polarity", cmp_o, iv);
                probe(1'b1, 16'd0, 16'd0, 8, lat, bc);
                check(lat == (s ? 3 : 1), "R2 latency", lat, s ? 3 : 1);
                check(cmp_o == !iv[0], "R3 polarity after change", cmp_o, !iv[0]);
            end
        end
        sync_en = 1'b0;
        inv_en = 1'b0;
        cmp_raw = 1'b0;
        settle(6);

        // R4: window sweep
        filt_en = 1'b1;
        filt_ctrl = 2'd0;
        for (int code = 0; code < 16; code++) begin
            filt_win = code[3:0];
            win = (code == 15) ? 32 : code + 2;
            for (int dl = -1; dl <= 0; dl++) begin
                settle(40);
                pulse(win + dl, win + 4, first, bc);
                exp_first = (dl == 0) ? win + 1 : 0;
                check(first == exp_first, "R4 window", first, exp_first);
            end
        end
        settle(40);

        // R5, R6: gating by reference selection
        filt_win = 4'd3;
        for (int e = 0; e < 2; e++) begin
            for (int c = 0; c < 4; c++) begin
                for (int r = 0; r < 2; r++) begin
                    filt_en = e[0];
                    filt_ctrl = c[1:0];
                    ref_sel = r[0];
                    settle(12);
                    pulse(2, 8, first, bc);
                    bypass = (e == 0) || (c == 1 && r == 1) || (c == 2 && r == 0);
                    check(first == (bypass ? 1 : 0), e == 0 ? "R6 filter off" : "R5 gating",
                          first, bypass ? 1 : 0);
                end
            end
        end
        filt_en = 1'b0;
        filt_ctrl = 2'd0;
        ref_sel = 1'b0;
        cmp_raw = 1'b0;
        settle(12);

        // R7, R10: edge-started blanking, length 6
        blank_len = 8'd6;
        for (int m = 0; m < 4; m++) begin
            blank_mode = 2'd0;
            cmp_raw = 1'b0;
            settle(4);
            blank_mode = m[1:0];
            probe(1'b1, 16'd0, 16'd0, 14, lat, bc);
            hit = m[0];
            check(bc == (hit ? 6 : 0), "R7 rise blank count", bc, hit ? 6 : 0);
            check(lat == (hit ? 8 : 1), "R10 rise held", lat, hit ? 8 : 1);
            blank_mode = 2'd0;
            settle(4);
            blank_mode = m[1:0];
            probe(1'b0, 16'd0, 16'd0, 14, lat, bc);
            hit = m[1];
            check(bc == (hit ? 6 : 0), "R7 fall blank count", bc, hit ? 6 : 0);
            check(lat == (hit ? 8 : 1), "R10 fall held", lat, hit ? 8 : 1);
        end

        // R7: edges removed by the filter do not blank; accepted ones do
        blank_mode = 2'd0;
        filt_en = 1'b1;
        filt_win = 4'd3;
        settle(12);
        blank_mode = 2'd1;
        pulse(2, 10, first, bc);
        check(bc == 0, "R7 filtered glitch no blank", bc, 0);
        check(first == 0, "R7 filtered glitch output", first, 0);
        settle(8);
        pulse(8, 14, first, bc);
        check(bc == 6, "R7 filtered edge blank count", bc, 6);
        check(first == 13, "R7 filtered edge output", first, 13);
        filt_en = 1'b0;
        blank_mode = 2'd0;
        cmp_raw = 1'b0;
        settle(12);

        // R9: blanking lengths
        foreach (blank_len_set[i]) begin end
        for (int i = 0; i < 4; i++) begin
            int ln;
            ln = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 6 : 255;
            blank_len = ln[7:0];
            blank_mode = 2'd0;
            cmp_raw = 1'b0;
            settle(4);
            blank_mode = 2'd1;
            probe(1'b1, 16'd0, 16'd0, ln + 6, lat, bc);
            check(bc == ln, "R9 blank length", bc, ln);
            check(lat == (ln == 0 ? 1 : ln + 2), "R10 release edge", lat, ln == 0 ? 1 : ln + 2);
        end
        blank_mode = 2'd0;
        cmp_raw = 1'b0;
        settle(6);

        // R8: trigger selection sweep
        blank_len = 8'd4;
        ext_en = 1'b1;
        for (int sl = 0; sl < 16; sl++) begin
            ext_sel = sl[3:0];
            for (int j = 0; j < 16; j++) begin
                probe(1'b0, 16'd1 << j, 16'd0, 7, lat, bc);
                check(bc == ((j == sl) ? 4 : 0), "R8 trigger select", bc, (j == sl) ? 4 : 0);
            end
        end
        ext_en = 1'b0;
        for (int sl = 0; sl < 16; sl++) begin
            ext_sel = sl[3:0];
            probe(1'b0, 16'd1 << sl, 16'd0, 7, lat, bc);
            check(bc == 0, "R8 trigger disabled", bc, 0);
        end

        // R9, R10: external start with simultaneous rise and a retrigger attempt
        ext_en = 1'b1;
        ext_sel = 4'd2;
        blank_len = 8'd5;
        settle(4);
        probe(1'b1, 16'h0004, 16'h0004, 14, lat, bc);
        check(bc == 5, "R9 no retrigger", bc, 5);
        check(lat == 7, "R10 held through external blank", lat, 7);
        check(cmp_o == 1'b1, "R10 resumed level", cmp_o, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    int blank_len_set[1];

endmodule